// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block brings a DRAM device out of power-up once software has finished programming the controller configuration. It sits idle until a start control bit makes a 0-to-1 transition. It then asks the PHY delay-locked loop to lock and waits for the acknowledge. A software bypass bit can release that wait if lock never arrives. After the DLL step it holds the device reset for a programmed time and waits a programmed time before raising CKE. It then issues four mode register set commands and one long ZQ calibration, with programmed gaps between them. At the end it raises a completion status bit that software polls.

The lock status and the captured delay-line value are exposed as status outputs. Software can also overwrite the delay value. The mode register contents are captured at the start edge, so software may change those inputs while the sequence runs. A finished sequence can be run again by clearing the start bit and setting it once more.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, and until a 0-to-1 transition of `startBit`, the block holds `initDone`, `dllDone`, `dllLockReq`, `cke`, `cmdValid` and `dllValue` at 0, and holds `dramResetN` at 0.
- R2: After the start edge, `dllLockReq` is 1 and no command is issued for as long as neither `dllLockAck` nor `bypassDll` is seen. `dramResetN` stays 0 during this wait, however long it lasts.
- R3: When `dllLockAck` is seen during the lock wait, `dllDone` becomes 1, `dllValue` takes the value of `dllLockValue`, and `dllLockReq` drops to 0.
- R4: When `bypassDll` is 1 during the lock wait, the sequence continues without lock. `dllDone` stays 0 and `dllValue` keeps its previous value.
- R5: A cycle with `dllValueWrEn` high loads `dllValueWrData` into `dllValue`, visible on the next cycle.
- R6: `dramResetN` rises `resetHoldCycles`+1 cycles after `dllDone` rises. `cke` rises `ckeWaitCycles`+1 cycles after `dramResetN`. `cke` is never 1 while `dramResetN` is 0.
- R7: Four MRS commands (`cmd`=1) are issued in the order bank 2, 3, 1, 0. Their `addr` values are `mr2Cfg`, `mr3Cfg`, `mr1Cfg` and `mr0Cfg`.
- R8: The first command comes 1 cycle after `cke` rises. Each later command follows the previous one by `tMrdCycles`+2 cycles.
- R9: The fifth command is ZQCL (`cmd`=2) with bank 0 and only `addr` bit 10 set. `initDone` rises `tZqinitCycles`+2 cycles after it.
- R10: Each command holds `cmdValid` high for exactly one cycle. In every other cycle, `cmd`, `bank` and `addr` are all 0 (NOP).
- R11: A 0-to-1 transition of `startBit` after completion clears `initDone` on the next cycle and reruns the whole sequence from the lock request. While `startBit` stays high after completion, nothing is restarted.
- R12: The mode register inputs are sampled at the start edge. Changes to them after that edge do not affect the commands of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startBit | input | 1 | Start control bit; its rising edge begins a run |
| bypassDll | input | 1 | Releases the DLL lock wait without lock |
| dllValueWrEn | input | 1 | Software write strobe for the delay value |
| dllValueWrData | input | DLY_W | Software write data for the delay value |
| resetHoldCycles | input | CNT_W | Reset hold time minus one, in cycles |
| ckeWaitCycles | input | CNT_W | Reset-release-to-CKE time minus one |
| tMrdCycles | input | CNT_W | Gap after each MRS, minus one idle cycle |
| tZqinitCycles | input | CNT_W | Gap after ZQCL before completion |
| mr0Cfg | input | ADDR_W | Mode register 0 value |
| mr1Cfg | input | ADDR_W | Mode register 1 value |
| mr2Cfg | input | ADDR_W | Mode register 2 value |
| mr3Cfg | input | ADDR_W | Mode register 3 value |
| dllLockAck | input | 1 | PHY DLL lock indication |
| dllLockValue | input | DLY_W | PHY locked delay-line value |
| dllLockReq | output | 1 | Request to the PHY to lock the DLL |
| dllDone | output | 1 | DLL lock achieved status |
| dllValue | output | DLY_W | Captured or software-written delay value |
| initDone | output | 1 | Initialization complete status |
| dramResetN | output | 1 | DRAM reset, active low |
| cke | output | 1 | DRAM clock enable |
| cmdValid | output | 1 | Command strobe |
| cmd | output | 3 | Command code: 0 NOP, 1 MRS, 2 ZQCL |
| bank | output | BANK_W | Command bank address |
| addr | output | ADDR_W | Command row/address bus |

## Verification
The hardest case to reach is the lock that never arrives. From the ports it looks the same as a slow lock, so the bench restarts with the acknowledge held low and lets several hundred cycles pass. During that time it confirms that no command, no reset release and no completion appear. Only then does it set the bypass bit, and it checks that the sequence finishes with the lock status still clear and the old delay value kept. The restart case is reached by clearing and setting the start bit after a completed run. The case where start stays high is held long enough to show that no second run begins.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_MRS  = 3'd1;
  localparam logic [2:0] CMD_ZQCL = 3'd2;

  localparam int NUM_MR   = 4;
  localparam int NUM_CMDS = NUM_MR + 1;
  localparam int ZQ_LONG_BIT = 10;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_CKE,
    SEL_MRD,
    SEL_ZQ,
    SEL_ZERO
  } cntSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLL,
    ST_RSTHOLD,
    ST_CKEWAIT,
    ST_GAP,
    ST_ISSUE,
    ST_DONE
  } seqState_e;

  typedef struct packed {
    logic    startSeq;
    logic    sampleCfg;
    logic    captureLock;
    logic    leaveDll;
    logic    loadCnt;
    cntSel_e cntSel;
    logic    decCnt;
    logic    releaseReset;
    logic    raiseCke;
    logic    issue;
    logic [2:0] issueIdx;
    logic    finish;
  } seqStrobe_t;

endpackage

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
  import dram_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBit,
  input  logic       bypassDll,
  input  logic       dllLockAck,
  input  logic       cntZero,
  output seqStrobe_t strobe
);

  seqState_e state, stateNext;
  logic       startPrev;
  logic [2:0] cmdIdx, cmdIdxNext;
  logic       startEdge;

  assign startEdge = startBit & ~startPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startPrev <= 1'b0;
      cmdIdx    <= '0;
    end else begin
      state     <= stateNext;
      startPrev <= startBit;
      cmdIdx    <= cmdIdxNext;
    end
  end

  always_comb begin
    strobe     = '0;
    strobe.cntSel = SEL_ZERO;
    stateNext  = state;
    cmdIdxNext = cmdIdx;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (startEdge) begin
          strobe.startSeq  = 1'b1;
          strobe.sampleCfg = 1'b1;
          stateNext        = ST_DLL;
        end
      end
      ST_DLL: begin
        if (dllLockAck) begin
          strobe.captureLock = 1'b1;
          strobe.leaveDll    = 1'b1;
          strobe.loadCnt     = 1'b1;
          strobe.cntSel      = SEL_HOLD;
          stateNext          = ST_RSTHOLD;
        end else if (bypassDll) begin
          strobe.leaveDll = 1'b1;
          strobe.loadCnt  = 1'b1;
          strobe.cntSel   = SEL_HOLD;
          stateNext       = ST_RSTHOLD;
        end
      end
      ST_RSTHOLD: begin
        if (cntZero) begin
          strobe.releaseReset = 1'b1;
          strobe.loadCnt      = 1'b1;
          strobe.cntSel       = SEL_CKE;
          stateNext           = ST_CKEWAIT;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_CKEWAIT: begin
        if (cntZero) begin
          strobe.raiseCke = 1'b1;
          strobe.loadCnt  = 1'b1;
          strobe.cntSel   = SEL_ZERO;
          cmdIdxNext      = '0;
          stateNext       = ST_GAP;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_GAP: begin
        if (cntZero) begin
          if (cmdIdx == 3'(NUM_CMDS)) begin
            strobe.finish = 1'b1;
            stateNext     = ST_DONE;
          end else begin
            strobe.issue    = 1'b1;
            strobe.issueIdx = cmdIdx;
            stateNext       = ST_ISSUE;
          end
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_ISSUE: begin
        strobe.loadCnt = 1'b1;
        strobe.cntSel  = (cmdIdx == 3'(NUM_CMDS - 1)) ? SEL_ZQ : SEL_MRD;
        cmdIdxNext     = cmdIdx + 3'd1;
        stateNext      = ST_GAP;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dram_init_dp.sv
module dram_init_dp
  import dram_init_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CNT_W-1:0]  resetHoldCycles,
  input  logic [CNT_W-1:0]  ckeWaitCycles,
  input  logic [CNT_W-1:0]  tMrdCycles,
  input  logic [CNT_W-1:0]  tZqinitCycles,
  input  logic [NUM_MR-1:0][ADDR_W-1:0] mrCfg,
  input  logic              dllValueWrEn,
  input  logic [DLY_W-1:0]  dllValueWrData,
  input  logic [DLY_W-1:0]  dllLockValue,
  output logic              cntZero,
  output logic              dllLockReq,
  output logic              dllDone,
  output logic [DLY_W-1:0]  dllValue,
  output logic              initDone,
  output logic              dramResetN,
  output logic              cke,
  output logic              cmdValid,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr
);

  logic [CNT_W-1:0] cnt, cntLoad;
  logic [NUM_MR-1:0][ADDR_W-1:0] mrReg;
  logic [2:0]        issueCmd;
  logic [BANK_W-1:0] issueBank;
  logic [ADDR_W-1:0] issueAddr;

  assign cntZero = (cnt == '0);

  always_comb begin
    unique case (strobe.cntSel)
      SEL_HOLD: cntLoad = resetHoldCycles;
      SEL_CKE:  cntLoad = ckeWaitCycles;
      SEL_MRD:  cntLoad = tMrdCycles;
      SEL_ZQ:   cntLoad = tZqinitCycles;
      default:  cntLoad = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.loadCnt) cnt <= cntLoad;
    else if (strobe.decCnt)  cnt <= cnt - 1'b1;
  end

  // One capture register per mode register
  for (genvar g = 0; g < NUM_MR; g++) begin : gMr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 mrReg[g] <= '0;
      else if (strobe.sampleCfg) mrReg[g] <= mrCfg[g];
    end
  end

  // Issue order: MR2, MR3, MR1, MR0, then ZQCL
  always_comb begin
    issueCmd  = CMD_MRS;
    issueBank = '0;
    issueAddr = '0;
    unique case (strobe.issueIdx)
      3'd0: begin issueBank = BANK_W'(2); issueAddr = mrReg[2]; end
      3'd1: begin issueBank = BANK_W'(3); issueAddr = mrReg[3]; end
      3'd2: begin issueBank = BANK_W'(1); issueAddr = mrReg[1]; end
      3'd3: begin issueBank = BANK_W'(0); issueAddr = mrReg[0]; end
      default: begin
        issueCmd  = CMD_ZQCL;
        issueAddr = ADDR_W'(1) << ZQ_LONG_BIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmd      <= CMD_NOP;
      bank     <= '0;
      addr     <= '0;
    end else if (strobe.issue) begin
      cmdValid <= 1'b1;
      cmd      <= issueCmd;
      bank     <= issueBank;
      addr     <= issueAddr;
    end else begin
      cmdValid <= 1'b0;
      cmd      <= CMD_NOP;
      bank     <= '0;
      addr     <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dllLockReq <= 1'b0;
      dllDone    <= 1'b0;
      initDone   <= 1'b0;
      dramResetN <= 1'b0;
      cke        <= 1'b0;
    end else begin
      if (strobe.startSeq) begin
        dllLockReq <= 1'b1;
        dllDone    <= 1'b0;
        initDone   <= 1'b0;
        dramResetN <= 1'b0;
        cke        <= 1'b0;
      end
      if (strobe.leaveDll)     dllLockReq <= 1'b0;
      if (strobe.captureLock)  dllDone    <= 1'b1;
      if (strobe.releaseReset) dramResetN <= 1'b1;
      if (strobe.raiseCke)     cke        <= 1'b1;
      if (strobe.finish)       initDone   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   dllValue <= '0;
    else if (strobe.captureLock) dllValue <= dllLockValue;
    else if (dllValueWrEn)       dllValue <= dllValueWrData;
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBit,
  input  logic              bypassDll,
  input  logic              dllValueWrEn,
  input  logic [DLY_W-1:0]  dllValueWrData,
  input  logic [CNT_W-1:0]  resetHoldCycles,
  input  logic [CNT_W-1:0]  ckeWaitCycles,
  input  logic [CNT_W-1:0]  tMrdCycles,
  input  logic [CNT_W-1:0]  tZqinitCycles,
  input  logic [ADDR_W-1:0] mr0Cfg,
  input  logic [ADDR_W-1:0] mr1Cfg,
  input  logic [ADDR_W-1:0] mr2Cfg,
  input  logic [ADDR_W-1:0] mr3Cfg,
  input  logic              dllLockAck,
  input  logic [DLY_W-1:0]  dllLockValue,
  output logic              dllLockReq,
  output logic              dllDone,
  output logic [DLY_W-1:0]  dllValue,
  output logic              initDone,
  output logic              dramResetN,
  output logic              cke,
  output logic              cmdValid,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr
);

  seqStrobe_t strobe;
  logic       cntZero;
  logic [NUM_MR-1:0][ADDR_W-1:0] mrCfg;

  assign mrCfg = {mr3Cfg, mr2Cfg, mr1Cfg, mr0Cfg};

  dram_init_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startBit   (startBit),
    .bypassDll  (bypassDll),
    .dllLockAck (dllLockAck),
    .cntZero    (cntZero),
    .strobe     (strobe)
  );

  dram_init_dp #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .DLY_W  (DLY_W)
  ) uDp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .resetHoldCycles (resetHoldCycles),
    .ckeWaitCycles   (ckeWaitCycles),
    .tMrdCycles      (tMrdCycles),
    .tZqinitCycles   (tZqinitCycles),
    .mrCfg           (mrCfg),
    .dllValueWrEn    (dllValueWrEn),
    .dllValueWrData  (dllValueWrData),
    .dllLockValue    (dllLockValue),
    .cntZero         (cntZero),
    .dllLockReq      (dllLockReq),
    .dllDone         (dllDone),
    .dllValue        (dllValue),
    .initDone        (initDone),
    .dramResetN      (dramResetN),
    .cke             (cke),
    .cmdValid        (cmdValid),
    .cmd             (cmd),
    .bank            (bank),
    .addr            (addr)
  );

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startBit,
  input logic              dllLockReq,
  input logic              initDone,
  input logic              dramResetN,
  input logic              cke,
  input logic              cmdValid,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] bank,
  input logic [ADDR_W-1:0] addr
);

  AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);  // R10

  AST_NOP_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (cmd == 3'd0 && bank == '0 && addr == '0));  // R10

  AST_NO_CMD_IN_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    dllLockReq |-> (!cmdValid && !dramResetN));  // R2

  AST_CKE_NEEDS_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    cke |-> dramResetN);  // R6

  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cke);  // R8

  AST_DONE_CLEARS_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(initDone) |-> $past(startBit));  // R11

endmodule

bind dram_init_seq dram_init_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startBit   (startBit),
  .dllLockReq (dllLockReq),
  .initDone   (initDone),
  .dramResetN (dramResetN),
  .cke        (cke),
  .cmdValid   (cmdValid),
  .cmd        (cmd),
  .bank       (bank),
  .addr       (addr)
);

// File: tb/dram_init_seq_test.sv
module dram_init_seq_test;

  localparam int CNT_W  = 16;
  localparam int ADDR_W = 14;
  localparam int BANK_W = 3;
  localparam int DLY_W  = 8;
  localparam int HOLD = 5;
  localparam int CKEW = 4;
  localparam int MRD  = 3;
  localparam int ZQ   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startBit = 1'b0, bypassDll = 1'b0, dllValueWrEn = 1'b0, dllLockAck = 1'b0;
  logic [DLY_W-1:0]  dllValueWrData = '0, dllLockValue = '0;
  logic [CNT_W-1:0]  resetHoldCycles = CNT_W'(HOLD), ckeWaitCycles = CNT_W'(CKEW);
  logic [CNT_W-1:0]  tMrdCycles = CNT_W'(MRD), tZqinitCycles = CNT_W'(ZQ);
  logic [ADDR_W-1:0] mr0Cfg = '0, mr1Cfg = '0, mr2Cfg = '0, mr3Cfg = '0;
  logic dllLockReq, dllDone, initDone, dramResetN, cke, cmdValid;
  logic [DLY_W-1:0]  dllValue;
  logic [2:0]        cmd;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] addr;

  always #2.5 clk = ~clk;

  dram_init_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DLY_W(DLY_W)) uut (
    .clk(clk), .rstN(rstN), .startBit(startBit), .bypassDll(bypassDll),
    .dllValueWrEn(dllValueWrEn), .dllValueWrData(dllValueWrData),
    .resetHoldCycles(resetHoldCycles), .ckeWaitCycles(ckeWaitCycles),
    .tMrdCycles(tMrdCycles), .tZqinitCycles(tZqinitCycles),
    .mr0Cfg(mr0Cfg), .mr1Cfg(mr1Cfg), .mr2Cfg(mr2Cfg), .mr3Cfg(mr3Cfg),
    .dllLockAck(dllLockAck), .dllLockValue(dllLockValue),
    .dllLockReq(dllLockReq), .dllDone(dllDone), .dllValue(dllValue),
    .initDone(initDone), .dramResetN(dramResetN), .cke(cke),
    .cmdValid(cmdValid), .cmd(cmd), .bank(bank), .addr(addr)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Event log, sampled at falling edges
  int cyc = 0;
  int cmdCount = 0;
  int cmdCyc[8];
  int cmdCode[8];
  int cmdBank[8];
  int cmdAddr[8];
  int rstRise, ckeRise, doneRise, dllRise;
  logic pRst = 1'b0, pCke = 1'b0, pDone = 1'b0, pDll = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cmdValid && cmdCount < 8) begin
      cmdCyc[cmdCount]  <= cyc;
      cmdCode[cmdCount] <= int'(cmd);
      cmdBank[cmdCount] <= int'(bank);
      cmdAddr[cmdCount] <= int'(addr);
    end
    if (cmdValid) cmdCount <= cmdCount + 1;
    if (dramResetN && !pRst) rstRise  <= cyc;
    if (cke && !pCke)        ckeRise  <= cyc;
    if (initDone && !pDone)  doneRise <= cyc;
    if (dllDone && !pDll)    dllRise  <= cyc;
    pRst <= dramResetN; pCke <= cke; pDone <= initDone; pDll <= dllDone;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk);
    cmdCount = 0;
    rstRise = -1; ckeRise = -1; doneRise = -1; dllRise = -1;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (initDone) break;
    end
    @(negedge clk);
  endtask

  task automatic checkCommands(input string tag, input int a0, input int a1, input int a2, input int a3);
    int expBank[4] = '{2, 3, 1, 0};
    int expAddr[4];
    expAddr = '{a2, a3, a1, a0};
    check(cmdCount == 5, {tag, " R7 command count"}, cmdCount, 5);
    for (int i = 0; i < 4; i++) begin
      check(cmdCode[i] == 1, {tag, " R7 MRS code"}, cmdCode[i], 1);
      check(cmdBank[i] == expBank[i], {tag, " R7 MRS bank order"}, cmdBank[i], expBank[i]);
      check(cmdAddr[i] == expAddr[i], {tag, " R12 MRS value"}, cmdAddr[i], expAddr[i]);
    end
    for (int i = 1; i < 5; i++)
      check(cmdCyc[i] - cmdCyc[i-1] == MRD + 2, {tag, " R8 command gap"},
            cmdCyc[i] - cmdCyc[i-1], MRD + 2);
    check(cmdCyc[0] - ckeRise == 1, {tag, " R8 first command after cke"}, cmdCyc[0] - ckeRise, 1);
    check(cmdCode[4] == 2, {tag, " R9 ZQCL code"}, cmdCode[4], 2);
    check(cmdBank[4] == 0, {tag, " R9 ZQCL bank"}, cmdBank[4], 0);
    check(cmdAddr[4] == 1024, {tag, " R9 ZQCL address"}, cmdAddr[4], 1024);
    check(doneRise - cmdCyc[4] == ZQ + 2, {tag, " R9 done delay"}, doneRise - cmdCyc[4], ZQ + 2);
    check(ckeRise - rstRise == CKEW + 1, {tag, " R6 cke delay"}, ckeRise - rstRise, CKEW + 1);
  endtask

  task automatic testResetState();
    check(initDone == 0, "R1 initDone at reset", initDone, 0);
    check(dllDone == 0, "R1 dllDone at reset", dllDone, 0);
    check(dllLockReq == 0, "R1 lock request at reset", dllLockReq, 0);
    check(cke == 0 && dramResetN == 0, "R1 cke/reset at reset", {cke, dramResetN}, 0);
    check(cmdValid == 0, "R1 no command at reset", cmdValid, 0);
    check(dllValue == 0, "R1 dllValue at reset", dllValue, 0);
    repeat (10) @(negedge clk);
    check(dllLockReq == 0 && cmdCount == 0, "R1 idle without start", cmdCount, 0);
  endtask

  task automatic testLockPath();
    mr0Cfg = 14'h0123; mr1Cfg = 14'h0456; mr2Cfg = 14'h0789; mr3Cfg = 14'h0ABC;
    clearLog();
    startBit = 1'b1;
    @(negedge clk);
    check(dllLockReq == 1, "R2 lock request after start", dllLockReq, 1);
    mr0Cfg = 14'h3FFF; mr1Cfg = 14'h3FFF; mr2Cfg = 14'h3FFF; mr3Cfg = 14'h3FFF;
    repeat (3) @(negedge clk);
    check(dramResetN == 0 && cmdCount == 0, "R2 waiting for lock", cmdCount, 0);
    dllLockValue = 8'h5A;
    dllLockAck = 1'b1;
    @(negedge clk);
    check(dllDone == 1, "R3 dllDone after lock", dllDone, 1);
    check(dllValue == 8'h5A, "R3 captured delay value", dllValue, 8'h5A);
    check(dllLockReq == 0, "R3 lock request dropped", dllLockReq, 0);
    waitDone();
    dllLockAck = 1'b0;
    check(initDone == 1, "R9 initDone after lock run", initDone, 1);
    check(rstRise - dllRise == HOLD + 1, "R6 reset hold", rstRise - dllRise, HOLD + 1);
    checkCommands("lock", 14'h0123, 14'h0456, 14'h0789, 14'h0ABC);
  endtask

  task automatic testHeldStart();
    clearLog();
    repeat (50) @(negedge clk);
    check(cmdCount == 0, "R11 held start does not restart", cmdCount, 0);
    check(initDone == 1, "R11 done stays while start held", initDone, 1);
  endtask

  task automatic testSwWrite();
    dllValueWrData = 8'h33;
    dllValueWrEn = 1'b1;
    @(negedge clk);
    dllValueWrEn = 1'b0;
    check(dllValue == 8'h33, "R5 software delay write", dllValue, 8'h33);
  endtask

  task automatic testNoLockBypass();
    mr0Cfg = 14'h0011; mr1Cfg = 14'h0022; mr2Cfg = 14'h0033; mr3Cfg = 14'h0044;
    startBit = 1'b0;
    @(negedge clk);
    clearLog();
    startBit = 1'b1;
    @(negedge clk);
    check(initDone == 0, "R11 restart clears done", initDone, 1'b0);
    check(cke == 0, "R11 restart drops cke", cke, 0);
    repeat (300) @(negedge clk);
    check(cmdCount == 0, "R2 no command without lock", cmdCount, 0);
    check(dllLockReq == 1, "R2 lock request held", dllLockReq, 1);
    check(dramResetN == 0, "R2 reset held without lock", dramResetN, 0);
    check(initDone == 0, "R2 no completion without lock", initDone, 0);
    bypassDll = 1'b1;
    waitDone();
    bypassDll = 1'b0;
    check(initDone == 1, "R4 completes after bypass", initDone, 1);
    check(dllDone == 0, "R4 dllDone stays clear", dllDone, 0);
    check(dllValue == 8'h33, "R4 delay value kept", dllValue, 8'h33);
    checkCommands("bypass", 14'h0011, 14'h0022, 14'h0033, 14'h0044);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstRise = -1; ckeRise = -1; doneRise = -1; dllRise = -1;
    repeat (3) @(negedge clk);
    testResetState();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testResetState();
    testLockPath();
    testHeldStart();
    testSwWrite();
    testNoLockBypass();
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule